// File: doc/BRIEF.md
# Register List Walker for Block Transfers

This block sequences the registers named by a multiple-register load or store. When an instruction starts, the 16-bit register mask from the instruction word is captured. From then on the block presents the number of the lowest register that has not yet been moved. A sequencer uses that number to select both the read port and the write port for the transfer. Each cycle in which the sequencer raises its step input, the block drops the presented register from the pending set. The next higher register then appears on the following cycle. A flag tells the sequencer when the pending set is exhausted, so that it can leave its transfer loop.

The block also feeds an operand bus that the address arithmetic reads. It can drive four values:
- nothing;
- the constant 3;
- four times the number of registers in the captured mask;
- that same product with its two low bits set.

The product gives the size of the transfer in bytes, which is used to find the start address. The constant 3 lets the arithmetic unit subtract 4 from a link value by using its borrow.

Top module: `regset_walker`

## Requirements
- R1: After a synchronous active-low reset, `empty_o` is 1, `reg_idx_o` is 0 and the captured count is 0, so operand mode 2 yields 0.
- R2: When `load_i` is high, the pending set becomes `list_i` and the count becomes its population count (0 to 16) on that edge. `empty_o` is 0 on the next cycle exactly when `list_i` is non-zero; an all-zero mask makes it 1 at once.
- R3: While `empty_o` is 0, `reg_idx_o` is the lowest bit position (0 to 15) set in the pending set; while `empty_o` is 1, `reg_idx_o` is 0.
- R4: When `step_i` is high, `load_i` is low and the set is not empty, the presented register is removed on that edge, so registers come out in ascending order, one per step.
- R5: A step with an empty pending set has no effect: `empty_o` stays 1 and `reg_idx_o` stays 0.
- R6: When `load_i` and `step_i` are high together, the load wins and the new mask is captured whole.
- R7: Operand mode 0 (`abus_sel_i` = 2'b00) drives `abus_drive_o` = 0 and `abus_o` = 0; every other mode drives `abus_drive_o` = 1.
- R8: Operand mode 1 (2'b01) drives the constant 3 on `abus_o`.
- R9: Operand mode 2 (2'b10) drives count × 4, zero-extended to 32 bits.
- R10: Operand mode 3 (2'b11) drives count × 4 + 3 (bits 1:0 set).
- R11: The count changes only on a load; stepping through the set leaves it as it was captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Capture `list_i` as the new pending set |
| list_i | input | 16 | Register mask from the instruction |
| step_i | input | 1 | Sequencer advance: retire the presented register |
| abus_sel_i | input | 2 | Operand mode: 0 none, 1 constant 3, 2 count×4, 3 count×4+3 |
| reg_idx_o | output | 4 | Number of the lowest pending register |
| empty_o | output | 1 | No registers remain |
| abus_o | output | 32 | Operand bus value |
| abus_drive_o | output | 1 | Operand bus is being driven |

## Verification
The bench tries several kinds of mask:
- The all-zero mask shows whether the empty flag is raised straight after capture.
- The full mask and the mask with only the two end bits set test the top and bottom positions of the encoder and the 16-way count.
- Random masks, with gaps in the stepping, test ascending order and whether each step removes exactly one register.

A reload in the middle of a walk, together with a step in the same cycle, tells whether the load takes priority over the step. All four operand modes rotate throughout the run, so a count that changes during stepping would appear as a wrong operand value.

// File: rtl/regset_walker_pkg.sv
// Package: shared operand-mode encoding for the register list walker.
package regset_walker_pkg;
    typedef enum logic [1:0] {
        ABUS_NONE   = 2'b00,
        ABUS_THREE  = 2'b01,
        ABUS_SIZE   = 2'b10,
        ABUS_SIZE3  = 2'b11
    } abus_mode_e;
endpackage

// File: rtl/rw_lowbit_finder.sv
// Module: rw_lowbit_finder
// Finds the lowest set bit of a mask. Assumes the caller ignores idx when
// none is set; idx is 0 in that case and none_o is high.
module rw_lowbit_finder #(
    parameter int LIST_W = 16,
    localparam int IDX_W = $clog2(LIST_W)
) (
    input  logic [LIST_W-1:0] mask_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              none_o
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        idx_o = '0;
        for (int i = LIST_W - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IDX_W'(i);
        end
    end

    // Flag an empty mask.
    assign none_o = (mask_i == '0);
endmodule

// File: rtl/rw_popcount.sv
// Module: rw_popcount
// Counts the set bits of a mask. Pure combinational; the result width holds
// LIST_W itself.
module rw_popcount #(
    parameter int LIST_W = 16,
    localparam int CNT_W = $clog2(LIST_W + 1)
) (
    input  logic [LIST_W-1:0] mask_i,
    output logic [CNT_W-1:0]  count_o
);
    // Accumulate one per set bit.
    always_comb begin
        count_o = '0;
        for (int i = 0; i < LIST_W; i++) begin
            count_o = count_o + CNT_W'(mask_i[i]);
        end
    end
endmodule

// File: rtl/rw_abus_mux.sv
// Module: rw_abus_mux
// Forms the operand bus value from the captured register count. Assumes
// count*4+3 fits in DATA_W.
module rw_abus_mux
    import regset_walker_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] abus_o,
    output logic              drive_o
);
    logic [DATA_W-1:0] bytes;
    assign bytes = DATA_W'(count_i) << 2;

    // Pick the operand form selected by the mode.
    always_comb begin
        unique case (abus_mode_e'(sel_i))
            ABUS_NONE:  begin abus_o = '0;                    drive_o = 1'b0; end
            ABUS_THREE: begin abus_o = DATA_W'(3);            drive_o = 1'b1; end
            ABUS_SIZE:  begin abus_o = bytes;                 drive_o = 1'b1; end
            default:    begin abus_o = bytes | DATA_W'(3);    drive_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/regset_walker.sv
// Module: regset_walker
// Holds the pending register set of a block transfer and retires one
// register per step, lowest first. It also drives an operand derived from
// the register count captured at load. Assumes the sequencer does not
// step past empty (a step while empty is harmless).
module regset_walker
    import regset_walker_pkg::*;
#(
    parameter int LIST_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LIST_W),
    localparam int CNT_W = $clog2(LIST_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [15:0]       list_i,
    input  logic              step_i,
    input  logic [1:0]        abus_sel_i,
    output logic [3:0]        reg_idx_o,
    output logic              empty_o,
    output logic [31:0]       abus_o,
    output logic              abus_drive_o
);
    logic [LIST_W-1:0] pending;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  new_count;
    logic [IDX_W-1:0]  low_idx;
    logic              none;

    rw_lowbit_finder #(.LIST_W(LIST_W)) u_find (
        .mask_i (pending),
        .idx_o  (low_idx),
        .none_o (none)
    );

    rw_popcount #(.LIST_W(LIST_W)) u_cnt (
        .mask_i  (list_i),
        .count_o (new_count)
    );

    // Capture on load, else drop the presented register on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            count   <= '0;
        end else if (load_i) begin
            pending <= list_i;
            count   <= new_count;
        end else if (step_i && !none) begin
            pending[low_idx] <= 1'b0;
        end
    end

    assign reg_idx_o = low_idx;
    assign empty_o   = none;

    rw_abus_mux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_abus (
        .sel_i   (abus_sel_i),
        .count_i (count),
        .abus_o  (abus_o),
        .drive_o (abus_drive_o)
    );

    // R2: a load captures the population count of the mask.
    a_r2_load_count: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> int'(count) == $countones($past(list_i)));

    // R3: the presented register is set and nothing below it is.
    a_r3_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_o |-> pending[reg_idx_o] &&
            ((pending & ((LIST_W'(1) << reg_idx_o) - LIST_W'(1))) == '0));

    // R4: a step on a non-empty set removes exactly one register.
    a_r4_one_retired: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !empty_o) |=>
            $countones(pending) == $countones($past(pending)) - 1);

    // R5: a step on an empty set leaves it empty.
    a_r5_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && empty_o) |=> empty_o);

    // R11: the count only moves on a load.
    a_r11_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(count));

    // R7: mode 0 leaves the operand bus undriven and zero.
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (abus_sel_i == 2'b00) |-> (abus_o == '0) && !abus_drive_o);
endmodule

// File: tb/sim_regset_walker.sv
module sim_regset_walker;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] list_i = '0;
    logic        step_i = 1'b0;
    logic [1:0]  abus_sel_i = '0;
    logic [3:0]  reg_idx_o;
    logic        empty_o;
    logic [31:0] abus_o;
    logic        abus_drive_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model: pending registers in issue order, and captured count.
    int q[$];
    int m_cnt = 0;

    regset_walker u0 (.*);

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        longint ea;
        int ed;
        chk("R2/R5 empty", empty_o, q.size() == 0);
        chk("R3/R4 index", reg_idx_o, q.size() ? q[0] : 0);
        case (abus_sel_i)
            2'd0: begin ea = 0;               ed = 0; end
            2'd1: begin ea = 3;               ed = 1; end
            2'd2: begin ea = m_cnt * 4;       ed = 1; end
            default: begin ea = m_cnt * 4 + 3; ed = 1; end
        endcase
        chk(abus_sel_i == 0 ? "R7 abus" : abus_sel_i == 1 ? "R8 abus" :
            abus_sel_i == 2 ? "R9/R11 abus" : "R10/R11 abus", abus_o, ea);
        chk("R7 drive", abus_drive_o, ed);
    endtask

    // One cycle: drive at negedge, model the edge, compare at next negedge.
    task automatic tick(bit ld, logic [15:0] lst, bit st, logic [1:0] sel);
        load_i = ld; list_i = lst; step_i = st; abus_sel_i = sel;
        @(posedge clk);
        if (ld) begin
            q.delete();
            for (int i = 0; i < 16; i++) if (lst[i]) q.push_back(i);
            m_cnt = q.size();
        end else if (st && q.size() > 0) begin
            void'(q.pop_front());
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic walk(logic [15:0] lst);
        tick(1, lst, 0, 2'd2);
        for (int n = 0; n < 20; n++) tick(0, '0, 1, 2'(n));
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        abus_sel_i = 2'd2;
        #1;
        chk("R1 reset empty", empty_o, 1);
        chk("R1 reset index", reg_idx_o, 0);
        chk("R1 reset count", abus_o, 0);
        rst_n = 1'b1;
        // R5: step while empty after reset
        tick(0, '0, 1, 2'd3);
        // R2: empty mask is empty at once; R8 constant
        tick(1, 16'h0000, 0, 2'd1);
        tick(0, '0, 1, 2'd3);
        walk(16'hFFFF);
        walk(16'h8001);
        walk(16'h0001);
        walk(16'h8000);
        // R6: reload with step mid-walk
        tick(1, 16'h0F0F, 0, 2'd3);
        tick(0, '0, 1, 2'd2);
        tick(1, 16'hA000, 1, 2'd3);
        chk("R6 load wins", reg_idx_o, 13);
        tick(0, '0, 1, 2'd0);
        tick(0, '0, 1, 2'd1);
        tick(0, '0, 1, 2'd2);
        // Random masks with gapped stepping and reloads
        for (int k = 0; k < 300; k++) begin
            logic [15:0] r;
            r = 16'($urandom);
            if (k % 7 == 0) r = r & 16'($urandom);
            tick(1, r, 1'($urandom), 2'($urandom));
            for (int n = 0; n < 22; n++)
                tick(($urandom % 40) == 0, 16'($urandom), 1'($urandom), 2'($urandom));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule